// File: doc/BRIEF.md
# Cascadable Serial Configuration Bitstream Reader

This block is the read side of a serial memory that loads an FPGA running in master-serial mode. A bit image is held in a word-organised synchronous store. Every rising edge of the configuration clock on which the block is selected and enabled puts the next image bit on the data output, starting at bit 0. The data output is modelled as a value plus an enable flag that stands for the tri-state driver.

A combined control input either clears the bit counter or enables the output, depending on its level. Its polarity is chosen by a strap input. A serial-enable input switches the block into programming mode. In that mode loading stops, and image words may be written through a simple word port.

When the last bit has gone out, an active-low chain-enable output selects the next reader in a daisy chain. The block then releases the data line, so that the next reader continues the stream on the following edge. While data is being read, the chain-enable output follows a three-phase rule:
- it holds low;
- it then tracks the chip-enable input;
- after a clear, it stays high until the whole image has been read again.

Top module: `cfg_stream_reader`

## Requirements
- R1: After the synchronous reset `rst` is released, `data_oe` is 0, `ce_out_n` is 1 and the next read returns image bit 0.
- R2: Image bit a lives in word a/WORD_W at bit position a mod WORD_W. Bits come out in ascending address order. On the k-th selected edge after a clear, `data_out` carries bit k-1 and `data_oe` is 1.
- R3: A clock edge that samples `ctl_ro` at its clear level (with `ser_en` high) clears the counter. After that edge `data_oe` is 0 and `ce_out_n` is 1, whatever `ce_n` is. The next read starts again at bit 0.
- R4: An edge that samples `ce_n` high with `ctl_ro` at its enable level is a standby edge. It drops `data_oe` and does not advance the counter, so reading resumes with the next unread bit.
- R5: On the edge that drives the last bit (address DEPTH_BITS-1), `ce_out_n` goes low. On every later selected edge `data_oe` is 0; the counter does not wrap.
- R6: Once `ce_out_n` is low it stays low while `ce_n` is low and `ctl_ro` is at its enable level. After the first standby edge it equals the `ce_n` value sampled at each edge. After a clear edge it stays high until the last bit has been driven again.
- R7: With `ctl_invert` = 0, `ctl_ro` low is the clear level and high is the enable level. With `ctl_invert` = 1 the two levels swap.
- R8: While `ser_en` is low, `ce_n` and `ctl_ro` have no effect. The counter and `ce_out_n` hold their values and `data_oe` is 0 after the next edge. A word write (`ld_we`) is stored only while `ser_en` is low.
- R9: With two readers chained (`ce_out_n` of the first driving `ce_n` of the second), the merged stream equals image one followed by image two, with no gap. The two `data_oe` flags are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_invert | input | 1 | Polarity strap for `ctl_ro` |
| ser_en | input | 1 | High for loading the FPGA, low for programming mode |
| ce_n | input | 1 | Chip enable, active low |
| ctl_ro | input | 1 | Combined clear / output-enable control |
| ld_we | input | 1 | Image word write strobe (programming mode only) |
| ld_idx | input | IDX_W | Image word index |
| ld_word | input | WORD_W | Image word data |
| data_out | output | 1 | Serial data bit, 0 while released |
| data_oe | output | 1 | Data driver enable (1 = driving) |
| ce_out_n | output | 1 | Chain-enable output to the next reader, active low |

## Verification
Every output is registered, so each result is due exactly one clock edge after the inputs that cause it:
- a selected edge drives the next bit and raises `data_oe`;
- a clear, standby or programming edge drops `data_oe`;
- `ce_out_n` changes on the edge that drives the last bit or that samples a new phase condition.

The bench changes inputs only on falling edges and samples all outputs at the next falling edge, half a period after the edge that produced them. From this it computes every expected value directly from the edge count since the last clear. In the two-reader chain, the hand-over is checked at the edge after the first reader's last bit.

// File: rtl/cfgsr_pkg.sv
package cfgsr_pkg;

    // Phase of the chain-enable output
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,   // output high, image not yet exhausted
        PH_HOLD   = 2'd1,   // output low after the last bit
        PH_FOLLOW = 2'd2    // output tracks ce_n
    } chain_ph_e;

    // Decoded operating condition for one clock edge
    typedef struct packed {
        logic prog;   // programming mode: everything frozen
        logic clr;    // control at clear level
        logic run;    // selected and enabled: advance
        logic stby;   // enabled but chip enable high
    } mode_t;

    function automatic mode_t decode_mode(
        input logic ser_en,
        input logic ce_n,
        input logic ctl_ro,
        input logic ctl_invert
    );
        mode_t m;
        logic  en_lvl;
        en_lvl = ctl_ro ^ ctl_invert;
        m.prog = ~ser_en;
        m.clr  = ser_en & ~en_lvl;
        m.run  = ser_en & en_lvl & ~ce_n;
        m.stby = ser_en & en_lvl & ce_n;
        return m;
    endfunction

endpackage

// File: rtl/cfgsr_decode.sv
module cfgsr_decode
    import cfgsr_pkg::*;
(
    input  logic  ser_en,
    input  logic  ce_n,
    input  logic  ctl_ro,
    input  logic  ctl_invert,
    output mode_t mode
);
    always_comb begin
        mode = decode_mode(ser_en, ce_n, ctl_ro, ctl_invert);
    end
endmodule

// File: rtl/cfgsr_store.sv
module cfgsr_store #(
    parameter  int DEPTH_BITS = 65536,
    parameter  int WORD_W     = 32,
    localparam int ADDR_W     = $clog2(DEPTH_BITS),
    localparam int BSEL_W     = $clog2(WORD_W),
    localparam int IDX_W      = ADDR_W - BSEL_W,
    localparam int NWORDS     = DEPTH_BITS / WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_ok,
    input  logic              ld_we,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [WORD_W-1:0] ld_word,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_bit
);
    logic [WORD_W-1:0] words [NWORDS];
    logic [IDX_W-1:0]  rd_idx;
    logic [BSEL_W-1:0] rd_sel;

    assign rd_idx = rd_addr[ADDR_W-1:BSEL_W];
    assign rd_sel = rd_addr[BSEL_W-1:0];

    // Image storage: written only in programming mode
    always_ff @(posedge clk) begin
        if (ld_we && ld_ok) begin
            words[ld_idx] <= ld_word;
        end
    end

    // Synchronous single-bit read
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_bit <= 1'b0;
        end else if (rd_en) begin
            rd_bit <= words[rd_idx][rd_sel];
        end
    end
endmodule

// File: rtl/cfgsr_seq.sv
module cfgsr_seq
    import cfgsr_pkg::*;
#(
    parameter  int DEPTH_BITS = 65536,
    localparam int ADDR_W     = $clog2(DEPTH_BITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  mode_t             mode,
    output logic [ADDR_W-1:0] addr,
    output logic              take,
    output logic              last_take,
    output logic              oe_q
);
    localparam logic [ADDR_W-1:0] ADDR_MAX = ADDR_W'(DEPTH_BITS - 1);

    logic spent;

    assign take      = mode.run & ~spent;
    assign last_take = take & (addr == ADDR_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr  <= '0;
            spent <= 1'b0;
            oe_q  <= 1'b0;
        end else if (mode.prog) begin
            oe_q  <= 1'b0;
        end else if (mode.clr) begin
            addr  <= '0;
            spent <= 1'b0;
            oe_q  <= 1'b0;
        end else if (mode.run) begin
            if (!spent) begin
                oe_q <= 1'b1;
                if (addr == ADDR_MAX) begin
                    spent <= 1'b1;   // saturate, no wrap
                end else begin
                    addr <= addr + 1'b1;
                end
            end else begin
                oe_q <= 1'b0;        // release line for next device
            end
        end else if (mode.stby) begin
            oe_q <= 1'b0;
        end
    end
endmodule

// File: rtl/cfgsr_chain.sv
module cfgsr_chain
    import cfgsr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mode_t mode,
    input  logic  ce_n,
    input  logic  last_take,
    output logic  ce_out_n
);
    chain_ph_e ph;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_IDLE;
            ce_out_n <= 1'b1;
        end else if (mode.prog) begin
            ph       <= ph;
        end else if (mode.clr) begin
            ph       <= PH_IDLE;
            ce_out_n <= 1'b1;
        end else begin
            unique case (ph)
                PH_IDLE: begin
                    if (last_take) begin
                        ph       <= PH_HOLD;
                        ce_out_n <= 1'b0;
                    end
                end
                PH_HOLD: begin
                    if (mode.stby) begin
                        ph       <= PH_FOLLOW;
                        ce_out_n <= 1'b1;
                    end else if (mode.run) begin
                        ce_out_n <= 1'b0;
                    end
                end
                PH_FOLLOW: begin
                    ce_out_n <= ce_n;
                end
                default: begin
                    ph       <= PH_IDLE;
                    ce_out_n <= 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/cfg_stream_reader.sv
module cfg_stream_reader
    import cfgsr_pkg::*;
#(
    parameter  int DEPTH_BITS = 65536,
    parameter  int WORD_W     = 32,
    localparam int ADDR_W     = $clog2(DEPTH_BITS),
    localparam int IDX_W      = ADDR_W - $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_invert,
    input  logic              ser_en,
    input  logic              ce_n,
    input  logic              ctl_ro,
    input  logic              ld_we,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [WORD_W-1:0] ld_word,
    output logic              data_out,
    output logic              data_oe,
    output logic              ce_out_n
);
    mode_t             mode;
    logic [ADDR_W-1:0] addr;
    logic              take;
    logic              last_take;
    logic              oe_q;
    logic              rd_bit;

    cfgsr_decode u_dec (
        .ser_en     (ser_en),
        .ce_n       (ce_n),
        .ctl_ro     (ctl_ro),
        .ctl_invert (ctl_invert),
        .mode       (mode)
    );

    cfgsr_seq #(.DEPTH_BITS(DEPTH_BITS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .addr      (addr),
        .take      (take),
        .last_take (last_take),
        .oe_q      (oe_q)
    );

    cfgsr_store #(.DEPTH_BITS(DEPTH_BITS), .WORD_W(WORD_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .ld_ok   (mode.prog),
        .ld_we   (ld_we),
        .ld_idx  (ld_idx),
        .ld_word (ld_word),
        .rd_en   (take),
        .rd_addr (addr),
        .rd_bit  (rd_bit)
    );

    cfgsr_chain u_chain (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .ce_n      (ce_n),
        .last_take (last_take),
        .ce_out_n  (ce_out_n)
    );

    assign data_oe  = oe_q;
    assign data_out = rd_bit & oe_q;
endmodule

// File: rtl/cfgsr_chk.sv
module cfgsr_chk (
    input logic clk,
    input logic rst,
    input logic ctl_invert,
    input logic ser_en,
    input logic ce_n,
    input logic ctl_ro,
    input logic data_oe,
    input logic ce_out_n
);
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!data_oe && ce_out_n));

    a_r3_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (ser_en && !(ctl_ro ^ ctl_invert)) |=> (!data_oe && ce_out_n));

    a_r4_standby_quiet: assert property (@(posedge clk) disable iff (rst)
        (ser_en && (ctl_ro ^ ctl_invert) && ce_n) |=> !data_oe);

    a_r5_handover: assert property (@(posedge clk) disable iff (rst)
        (!ce_out_n && data_oe) |=> !data_oe);

    a_r6_stay_low: assert property (@(posedge clk) disable iff (rst)
        (!ce_out_n && ser_en && !ce_n && (ctl_ro ^ ctl_invert)) |=> !ce_out_n);

    a_r8_prog_frozen: assert property (@(posedge clk) disable iff (rst)
        !ser_en |=> ($stable(ce_out_n) && !data_oe));
endmodule

bind cfg_stream_reader cfgsr_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctl_invert (ctl_invert),
    .ser_en     (ser_en),
    .ce_n       (ce_n),
    .ctl_ro     (ctl_ro),
    .data_oe    (data_oe),
    .ce_out_n   (ce_out_n)
);

// File: tb/tb_cfg_stream_reader.sv
module tb_cfg_stream_reader;
    localparam int D   = 1024;
    localparam int WW  = 32;
    localparam int NW  = D / WW;
    localparam int IW  = $clog2(D) - $clog2(WW);

    logic clk = 1'b0;
    logic rst, ctl_invert, ser_en, ce_n, ctl_ro, ld_we;
    logic [IW-1:0] ld_idx;
    logic [WW-1:0] ld_word_a, ld_word_b;
    logic d0, oe0, ceo0, d1, oe1, ceo1;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    cfg_stream_reader #(.DEPTH_BITS(D), .WORD_W(WW)) dut (
        .clk(clk), .rst(rst), .ctl_invert(ctl_invert), .ser_en(ser_en),
        .ce_n(ce_n), .ctl_ro(ctl_ro), .ld_we(ld_we), .ld_idx(ld_idx),
        .ld_word(ld_word_a), .data_out(d0), .data_oe(oe0), .ce_out_n(ceo0));

    cfg_stream_reader #(.DEPTH_BITS(D), .WORD_W(WW)) dut_nxt (
        .clk(clk), .rst(rst), .ctl_invert(ctl_invert), .ser_en(ser_en),
        .ce_n(ceo0), .ctl_ro(ctl_ro), .ld_we(ld_we), .ld_idx(ld_idx),
        .ld_word(ld_word_b), .data_out(d1), .data_oe(oe1), .ce_out_n(ceo1));

    function automatic logic [31:0] img_word(input int dev, input int w);
        logic [31:0] x;
        x = 32'(w) * 32'h9E37_79B1;
        return x ^ (dev == 0 ? 32'h0F1E_2D3C : 32'h5A5A_C3C3) ^ {x[15:0], x[31:16]};
    endfunction

    function automatic logic exp_bit(input int dev, input int a);
        logic [31:0] wv;
        wv = img_word(dev, a / WW);
        return wv[a % WW];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; ser_en = 1'b0; ce_n = 1'b1; ctl_ro = 1'b1; ctl_invert = 1'b0;
        ld_we = 1'b0; ld_idx = '0; ld_word_a = '0; ld_word_b = '0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1: quiet after reset
        chk("R1 oe", 32'(oe0), 0);
        chk("R1 ceo", 32'(ceo0), 1);
        chk("R1 nxt oe", 32'(oe1), 0);
        chk("R1 nxt ceo", 32'(ceo1), 1);

        // Load images in programming mode
        ld_we = 1'b1;
        for (int w = 0; w < NW; w++) begin
            ld_idx = IW'(w);
            ld_word_a = img_word(0, w);
            ld_word_b = img_word(1, w);
            tick();
        end
        ld_we = 1'b0;

        // R8: programming mode ignores ce_n / ctl_ro
        ce_n = 1'b0; ctl_ro = 1'b1;
        for (int i = 0; i < 5; i++) begin
            tick();
            chk("R8 prog oe", 32'(oe0), 0);
            chk("R8 prog ceo", 32'(ceo0), 1);
        end

        // R3: clear level; a write attempt outside programming mode is ignored (R8)
        ser_en = 1'b1; ctl_ro = 1'b0;
        ld_we = 1'b1; ld_idx = '0;
        ld_word_a = ~img_word(0, 0); ld_word_b = ~img_word(1, 0);
        tick();
        ld_we = 1'b0;
        chk("R3 clear oe", 32'(oe0), 0);

        // R2 / R5 / R9: full chained read
        ctl_ro = 1'b1;
        for (int k = 1; k <= 2 * D + 2; k++) begin
            logic e0, e1, ed, am;
            tick();
            e0 = (k <= D);
            e1 = (k > D) && (k <= 2 * D);
            ed = e0 ? exp_bit(0, k - 1) : (e1 ? exp_bit(1, k - D - 1) : 1'b0);
            am = (oe0 & d0) | (oe1 & d1);
            chk("R2 oe first", 32'(oe0), 32'(e0));
            chk("R9 oe second", 32'(oe1), 32'(e1));
            chk("R9 merged stream", 32'(am), 32'(ed));
            chk("R9 no overlap", 32'(oe0 & oe1), 0);
            chk("R5 ceo first", 32'(ceo0), (k >= D) ? 0 : 1);
            chk("R5 ceo second", 32'(ceo1), (k >= 2 * D) ? 0 : 1);
        end

        // R6: follow phase, then clear, then blocked until re-read
        ce_n = 1'b1; tick(); chk("R6 follow hi", 32'(ceo0), 1);
        ce_n = 1'b0; tick(); chk("R6 follow lo", 32'(ceo0), 0);
        chk("R5 stays off", 32'(oe0), 0);
        ce_n = 1'b1; tick(); chk("R6 follow hi2", 32'(ceo0), 1);
        ce_n = 1'b0; tick(); chk("R6 follow lo2", 32'(ceo0), 0);
        ctl_ro = 1'b0; tick();
        chk("R6 clear ceo", 32'(ceo0), 1);
        chk("R3 clear oe", 32'(oe0), 0);
        ctl_ro = 1'b1;
        for (int k = 1; k <= D; k++) begin
            tick();
            chk("R3 restart bit", 32'(d0), 32'(exp_bit(0, k - 1)));
            chk("R6 blocked ceo", 32'(ceo0), (k >= D) ? 0 : 1);
        end

        // R4: standby mid-stream
        ctl_ro = 1'b0; tick();
        ctl_ro = 1'b1; ce_n = 1'b0;
        for (int k = 0; k < 10; k++) begin
            tick();
            chk("R4 pre bit", 32'(d0), 32'(exp_bit(0, k)));
        end
        ce_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R4 standby oe", 32'(oe0), 0);
        end
        ce_n = 1'b0;
        for (int k = 10; k < 13; k++) begin
            tick();
            chk("R4 resume oe", 32'(oe0), 1);
            chk("R4 resume bit", 32'(d0), 32'(exp_bit(0, k)));
        end

        // R3: clear while chip enable high
        ce_n = 1'b1; ctl_ro = 1'b0; tick();
        chk("R3 clear ce hi", 32'(oe0), 0);
        ce_n = 1'b0; ctl_ro = 1'b1; tick();
        chk("R3 bit0 after clear", 32'(d0), 32'(exp_bit(0, 0)));
        chk("R3 oe after clear", 32'(oe0), 1);

        // R7: inverted polarity
        ctl_invert = 1'b1; ctl_ro = 1'b1; tick();
        chk("R7 inv clear", 32'(oe0), 0);
        ctl_ro = 1'b0;
        for (int k = 0; k < 5; k++) begin
            tick();
            chk("R7 inv bit", 32'(d0), 32'(exp_bit(0, k)));
            chk("R7 inv oe", 32'(oe0), 1);
        end
        ctl_ro = 1'b1; tick();
        chk("R7 inv clear2", 32'(oe0), 0);
        ctl_ro = 1'b0; tick();
        chk("R7 inv restart", 32'(d0), 32'(exp_bit(0, 0)));

        // R8: write ignored while loading, counter frozen in programming mode
        ctl_invert = 1'b0; ctl_ro = 1'b0; tick();
        ctl_ro = 1'b1; ce_n = 1'b0;
        ld_we = 1'b1; ld_idx = '0; ld_word_a = ~img_word(0, 0);
        for (int k = 0; k < 5; k++) begin
            tick();
            chk("R8 write ignored", 32'(d0), 32'(exp_bit(0, k)));
        end
        ld_we = 1'b0;
        ser_en = 1'b0; ctl_ro = 1'b0;
        for (int k = 0; k < 4; k++) begin
            tick();
            chk("R8 prog oe off", 32'(oe0), 0);
            chk("R8 prog ceo held", 32'(ceo0), 1);
        end
        ser_en = 1'b1; ctl_ro = 1'b1; tick();
        chk("R8 resume bit5", 32'(d0), 32'(exp_bit(0, 5)));
        chk("R8 resume oe", 32'(oe0), 1);

        summary();
        $finish;
    end
endmodule